// File: doc/BRIEF.md
# One-Hot Staged Clock Post-Divider

This block divides an input clock by a ratio from 1 to 8. Software selects the ratio with an 8-bit code in which exactly one bit is set. Every write of the code byte lands in a staging register. The staged value only becomes the active ratio when a transfer event occurs. A transfer event is either a write of the code byte while the legacy display mode input is high, or a pulse on the misc-output write strobe. The misc-output transfer works in any mode.

A code that does not have exactly one bit set is never allowed to become active. When a transfer tries to use such a code, the active ratio stays as it was and an error flag is raised. Ratio changes are deferred to the end of the output period in progress, so the output never shows a shortened pulse. Odd ratios keep the output high for the larger half of the period. For ratio 1 the output passes the input clock through.

Top module: `onehot_postdiv`

## Requirements
- R1: After reset, the staging and active codes are both 8'h01 (divide by 1), `code_err_o` is 0, and `clk_div_o` follows `clk_i`.
- R2: Code bit k (bit 0 is the LSB), when it is the only bit set, selects divide by k+1. So 8'h01 gives /1, 8'h02 gives /2, and so on up to 8'h80 for /8.
- R3: A code-byte write with `vga_mode_i` high makes the written code active from the next clock edge. A code-byte write with `vga_mode_i` low only updates the staging register.
- R4: A pulse on `misc_we_i` copies the staging code into the active register, whatever the level of `vga_mode_i`.
- R5: A transfer whose code does not have exactly one bit set (this includes 8'h00) leaves the active code unchanged and sets `code_err_o` from the next edge. A later legal transfer clears `code_err_o`.
- R6: For a ratio N of 2 or more, the output period is N input cycles. The output is high for ceil(N/2) cycles and low for floor(N/2) cycles, measured at input rising edges. For N = 1 the output is the input clock itself.
- R7: A new active ratio takes effect only after the current output period completes. The first period at the new ratio starts with its high phase.
- R8: Without a transfer event, the active ratio does not change, even when `vga_mode_i` or `code_wdata_i` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_we_i | input | 1 | Write strobe for the code byte |
| code_wdata_i | input | 8 | One-hot divide code to be written |
| vga_mode_i | input | 1 | Legacy display mode; high lets a code write transfer at once |
| misc_we_i | input | 1 | Misc-output write strobe; triggers the staging-to-active copy |
| clk_div_o | output | 1 | Divided clock |
| code_err_o | output | 1 | High after a transfer was refused because the code was illegal |

## Verification
Every one of the eight legal codes is made active in turn. The output's high and low run lengths are measured for each, which separates an off-by-one in the bit-to-ratio mapping from an even/odd duty error. Illegal codes are tried through both transfer paths: a two-bit code written directly, and an all-zero code sent through the staging path. Each of these must keep the previous ratio while raising the flag. A switch from /8 to /3 is issued right at the start of an output period, and the full 11-cycle waveform is compared. This catches a ratio that is applied early, mid-period. Changing the code while the mode input is low, and toggling the mode input on its own, show that neither one alone moves the ratio.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

   // Which event, if any, requests a staging-to-active copy this cycle.
   typedef enum logic [1:0] {
      XFER_NONE  = 2'd0,
      XFER_WRITE = 2'd1,
      XFER_MISC  = 2'd2
   } xfer_src_e;

endpackage

// File: rtl/postdiv_stage.sv
module postdiv_stage
   import postdiv_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              code_we_i,
   input  logic [CODE_W-1:0] code_wdata_i,
   input  logic              vga_mode_i,
   input  logic              misc_we_i,
   output logic [CODE_W-1:0] active_o,
   output logic              err_o
);

   localparam int            CNT_W      = $clog2(CODE_W + 1);
   localparam logic [CODE_W-1:0] RST_CODE = {{(CODE_W-1){1'b0}}, 1'b1};

   logic [CODE_W-1:0] stage_q;
   logic [CODE_W-1:0] active_q;
   logic              err_q;
   logic [CODE_W-1:0] cand;
   logic [CNT_W-1:0]  ones;
   logic              legal;
   xfer_src_e         src;

   // A direct write wins over a misc pulse in the same cycle and carries the new data.
   always_comb begin
      if (code_we_i && vga_mode_i)
         src = XFER_WRITE;
      else if (misc_we_i)
         src = XFER_MISC;
      else
         src = XFER_NONE;
   end

   assign cand = (src == XFER_WRITE) ? code_wdata_i : stage_q;

   always_comb begin
      ones = '0;
      for (int k = 0; k < CODE_W; k++)
         ones = ones + CNT_W'(cand[k]);
   end

   assign legal = (ones == CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q  <= RST_CODE;
         active_q <= RST_CODE;
         err_q    <= 1'b0;
      end else begin
         if (code_we_i)
            stage_q <= code_wdata_i;
         if (src != XFER_NONE) begin
            if (legal) begin
               active_q <= cand;
               err_q    <= 1'b0;
            end else begin
               err_q    <= 1'b1;
            end
         end
      end
   end

   assign active_o = active_q;
   assign err_o    = err_q;

endmodule

// File: rtl/postdiv_decode.sv
module postdiv_decode #(
   parameter int CODE_W = 8,
   parameter int RW     = 4
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [RW-1:0]     ratio_o
);

   logic [RW-1:0] term [CODE_W];

   // Bit k contributes the ratio k+1; the code is one-hot, so an OR selects it.
   for (genvar k = 0; k < CODE_W; k++) begin : g_term
      assign term[k] = code_i[k] ? RW'(k + 1) : '0;
   end

   always_comb begin
      ratio_o = '0;
      for (int k = 0; k < CODE_W; k++)
         ratio_o = ratio_o | term[k];
   end

endmodule

// File: rtl/postdiv_counter.sv
module postdiv_counter #(
   parameter int RW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [RW-1:0] ratio_i,
   output logic          div_o,
   output logic [RW-1:0] run_o,
   output logic [RW-1:0] cnt_o
);

   localparam int XW = RW + 1;

   logic [RW-1:0] cnt_q, cnt_n;
   logic [RW-1:0] run_q, run_n;
   logic          div_q, div_n;
   logic          wrap;
   logic [XW-1:0] half_n;

   assign wrap   = ({1'b0, cnt_q} + XW'(1)) == {1'b0, run_q};
   assign cnt_n  = wrap ? '0 : cnt_q + RW'(1);
   // The ratio is resampled only as a period closes, so no pulse is cut short.
   assign run_n  = wrap ? ratio_i : run_q;
   assign half_n = ({1'b0, run_n} + XW'(1)) >> 1;
   assign div_n  = {1'b0, cnt_n} < half_n;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         run_q <= RW'(1);
         div_q <= 1'b1;
      end else begin
         cnt_q <= cnt_n;
         run_q <= run_n;
         div_q <= div_n;
      end
   end

   assign div_o = div_q;
   assign run_o = run_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/onehot_postdiv.sv
module onehot_postdiv #(
   parameter int CODE_W      = 8,
   parameter bit BYPASS_DIV1 = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              code_we_i,
   input  logic [CODE_W-1:0] code_wdata_i,
   input  logic              vga_mode_i,
   input  logic              misc_we_i,
   output logic              clk_div_o,
   output logic              code_err_o
);

   localparam int RW = $clog2(CODE_W + 1);

   initial begin
      assert (CODE_W >= 2 && CODE_W <= 32)
         else $error("onehot_postdiv: CODE_W must lie in 2..32");
   end

   logic [CODE_W-1:0] active_code;
   logic [RW-1:0]     ratio;
   logic [RW-1:0]     run_ratio;
   logic [RW-1:0]     cnt_q;
   logic              div_q;

   postdiv_stage #(.CODE_W(CODE_W)) u_stage (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .code_we_i    (code_we_i),
      .code_wdata_i (code_wdata_i),
      .vga_mode_i   (vga_mode_i),
      .misc_we_i    (misc_we_i),
      .active_o     (active_code),
      .err_o        (code_err_o)
   );

   postdiv_decode #(.CODE_W(CODE_W), .RW(RW)) u_decode (
      .code_i  (active_code),
      .ratio_o (ratio)
   );

   postdiv_counter #(.RW(RW)) u_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ratio_i (ratio),
      .div_o   (div_q),
      .run_o   (run_ratio),
      .cnt_o   (cnt_q)
   );

   if (BYPASS_DIV1) begin : g_bypass
      // Ratio 1 passes the input clock; switches occur only at a low-to-high safe point.
      assign clk_div_o = (run_ratio == RW'(1)) ? clk_i : div_q;
   end else begin : g_regonly
      assign clk_div_o = div_q;
   end

endmodule

// File: rtl/postdiv_chk.sv
module postdiv_chk #(
   parameter int CODE_W = 8,
   parameter int RW     = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              code_we_i,
   input logic [CODE_W-1:0] code_wdata_i,
   input logic              vga_mode_i,
   input logic              misc_we_i,
   input logic              code_err_o,
   input logic [CODE_W-1:0] active_i,
   input logic [RW-1:0]     run_i,
   input logic [RW-1:0]     cnt_i,
   input logic              div_i
);

   a_r5_illegal_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_we_i && vga_mode_i && $countones(code_wdata_i) != 1) |=> code_err_o);

   a_r3_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_we_i && vga_mode_i && $countones(code_wdata_i) == 1)
      |=> (!code_err_o && active_i == $past(code_wdata_i)));

   a_r5_active_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(active_i) == 1);

   a_r8_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(code_we_i && vga_mode_i) && !misc_we_i) |=> $stable(active_i));

   a_r7_switch_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i != $past(run_i)) |-> (cnt_i == '0));

   a_r6_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_i) |-> (cnt_i == '0));

endmodule

bind onehot_postdiv postdiv_chk #(.CODE_W(CODE_W), .RW(RW)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .code_we_i    (code_we_i),
   .code_wdata_i (code_wdata_i),
   .vga_mode_i   (vga_mode_i),
   .misc_we_i    (misc_we_i),
   .code_err_o   (code_err_o),
   .active_i     (active_code),
   .run_i        (run_ratio),
   .cnt_i        (cnt_q),
   .div_i        (div_q)
);

// File: tb/onehot_postdiv_tb.sv
module onehot_postdiv_tb;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       code_we_i = 1'b0;
   logic [7:0] code_wdata_i = 8'h00;
   logic       vga_mode_i = 1'b0;
   logic       misc_we_i = 1'b0;
   logic       clk_div_o;
   logic       code_err_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;
   logic s;

   always #4 clk_i = ~clk_i;

   onehot_postdiv u_dut (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .code_we_i    (code_we_i),
      .code_wdata_i (code_wdata_i),
      .vga_mode_i   (vga_mode_i),
      .misc_we_i    (misc_we_i),
      .clk_div_o    (clk_div_o),
      .code_err_o   (code_err_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk_i);
      #1;
      s = clk_div_o;
   endtask

   task automatic write_code(input logic [7:0] d, input logic vga);
      code_we_i = 1'b1; code_wdata_i = d; vga_mode_i = vga;
      step();
      code_we_i = 1'b0;
   endtask

   task automatic pulse_misc();
      misc_we_i = 1'b1;
      step();
      misc_we_i = 1'b0;
   endtask

   // R6: ratio 1 passes the input clock through
   task automatic check_bypass(input string req);
      int bad = 0;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk_i); #2; if (clk_div_o !== 1'b1) bad++;
         @(negedge clk_i); #2; if (clk_div_o !== 1'b0) bad++;
      end
      chk(bad == 0, req, "divide-by-1 follows input clock (bad samples)", bad, 0);
   endtask

   // R6: measure one full period after the next rising output
   task automatic measure(input int n, input string req);
      int h = 0, l = 0, g = 0;
      step();
      while (s !== 1'b0 && g < 64) begin step(); g++; end
      while (s !== 1'b1 && g < 64) begin step(); g++; end
      while (s === 1'b1 && g < 64) begin h++; step(); g++; end
      while (s === 1'b0 && g < 64) begin l++; step(); g++; end
      chk(h == (n + 1) / 2, req, $sformatf("/%0d high cycles", n), h, (n + 1) / 2);
      chk(l == n / 2, req, $sformatf("/%0d low cycles", n), l, n / 2);
   endtask

   task automatic t_reset();
      chk(code_err_o === 1'b0, "R1", "error flag after reset", code_err_o, 0);
      check_bypass("R1");
   endtask

   task automatic t_map();
      for (int n = 1; n <= 8; n++) begin
         write_code(8'h01 << (n - 1), 1'b1);
         chk(code_err_o === 1'b0, "R2", $sformatf("error flag for /%0d", n), code_err_o, 0);
         if (n == 1) check_bypass("R2");
         else measure(n, "R2");
      end
   endtask

   task automatic t_stage_then_misc();
      write_code(8'h04, 1'b1);
      measure(3, "R3");
      write_code(8'h40, 1'b0);               // R3: staged only
      measure(3, "R3");
      vga_mode_i = 1'b0;
      pulse_misc();                          // R4: copy staged /7
      measure(7, "R4");
   endtask

   task automatic t_illegal();
      write_code(8'h05, 1'b1);               // R5: two bits set
      chk(code_err_o === 1'b1, "R5", "flag after two-bit code", code_err_o, 1);
      measure(7, "R5");
      write_code(8'h00, 1'b0);               // R5: zero code staged, then copied
      chk(code_err_o === 1'b1, "R5", "flag kept before legal transfer", code_err_o, 1);
      pulse_misc();
      chk(code_err_o === 1'b1, "R5", "flag after zero code via misc", code_err_o, 1);
      measure(7, "R5");
      write_code(8'h02, 1'b1);
      chk(code_err_o === 1'b0, "R5", "flag cleared by legal write", code_err_o, 0);
      measure(2, "R5");
   endtask

   // R7: switch /8 -> /3 at period start; old period must complete
   task automatic t_switch();
      logic [10:0] got;
      logic [10:0] exp = 11'b11110000110;   // index 10 first
      int g = 0;
      write_code(8'h80, 1'b1);
      measure(8, "R7");
      step();
      while (s !== 1'b0 && g < 64) begin step(); g++; end
      while (s !== 1'b1 && g < 64) begin step(); g++; end
      code_we_i = 1'b1; code_wdata_i = 8'h04; vga_mode_i = 1'b1;
      got[10] = s;
      for (int i = 1; i <= 10; i++) begin
         step();
         if (i == 1) code_we_i = 1'b0;
         got[10 - i] = s;
      end
      chk(got == exp, "R7", "waveform across /8 to /3 switch", got, exp);
   endtask

   task automatic t_hold();
      for (int i = 0; i < 6; i++) begin
         vga_mode_i   = ~vga_mode_i;
         code_wdata_i = 8'h01 << i;
         step();
      end
      vga_mode_i = 1'b0;
      measure(3, "R8");
      chk(code_err_o === 1'b0, "R8", "flag unchanged without transfer", code_err_o, 0);
   endtask

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk_i);
      #1 rst_ni = 1'b1;
      t_reset();
      t_map();
      t_stage_then_misc();
      t_illegal();
      t_switch();
      t_hold();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule